// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block runs on the system clock and drives an external asynchronous static RAM. The RAM has a single shared data bus and two active-low strobes: a write strobe and an output strobe. A user on the clocked side presents one access at a time through a valid/ready handshake. Each access carries an address, write data and a direction flag. Reads return their data with a single-cycle valid pulse.

The block sequences the RAM address, both strobes and the direction of the data bus. Every timing window is a whole number of clock cycles and is set by a parameter. For a write, the address and data are driven for a setup window, the write strobe is pulsed low, and then both are held for a hold window. For a read, the bus is released and the output strobe is held low for an access window. The returned word is captured only at the end of that window.

The block never drives the bus while the RAM may be driving it. Between any two strobe assertions there is always a cycle in which both strobes are high. The pad buffer is outside the block: it gets separate outgoing data, incoming data and drive-enable signals.

Top module: `asram_ctrl`

## Requirements
- R1: After a synchronous reset, both strobes (`sram_we_n`, `sram_oe_n`) are 1, `sram_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: `req_ready` is 0 from the cycle after a request is accepted until the access completes. A `req_valid` seen while `req_ready` is 0 is ignored: it does not change the address, data or strobes of the ongoing access and starts no access.
- R3: For a write (`req_write` = 1), the address and write data are driven with `sram_dq_oe` = 1 and both strobes high for SETUP_CYC cycles. Then `sram_we_n` is 0 for exactly PULSE_CYC cycles while `sram_oe_n` stays 1.
- R4: After `sram_we_n` returns to 1, the write address, write data and `sram_dq_oe` = 1 stay unchanged for HOLD_CYC cycles. The bus is then released.
- R5: For a read (`req_write` = 0), `sram_oe_n` is 0 for exactly ACCESS_CYC cycles with the address stable, `sram_we_n` = 1 and `sram_dq_oe` = 0.
- R6: A read samples `sram_dq_in` at the end of the ACCESS_CYC-th cycle of the output strobe. It presents that word on `rsp_rdata` with `rsp_valid` high for exactly one cycle, in the cycle after the output strobe rises.
- R7: `sram_we_n` and `sram_oe_n` are never 0 in the same cycle. `sram_dq_oe` is never 1 while `sram_oe_n` is 0.
- R8: Any cycle in which a strobe falls is preceded by a cycle in which both strobes are 1.
- R9: While `req_ready` is 1, a request with `req_valid` = 1 is accepted at the next clock edge. `req_ready` is 1 for at least one cycle between two accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block idle, can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_rdata | output | DATA_W | Read data |
| sram_addr | output | ADDR_W | Address to RAM |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output strobe, active low |
| sram_dq_out | output | DATA_W | Data toward the bus pads |
| sram_dq_oe | output | 1 | Pad drive enable for the data bus |
| sram_dq_in | input | DATA_W | Data from the bus pads |

## Verification
On every cycle, the assertions check the following: the two strobes are mutually exclusive, the bus is never driven under an active output strobe, and a strobe only falls after a cycle with both strobes high. They also check the single-cycle response pulse, the drop of ready after acceptance, and the one-cycle setup and hold edges around the write strobe. The full window lengths can only be shown by the bench's scenarios, which compare the design against a reference model on every clock. These include the exact setup, pulse, hold and access counts, the captured read word, the data written into the RAM model, and requests ignored while busy. A RAM model that returns junk until the access window has elapsed exposes a read sampled too early.

// File: rtl/asram_pkg.sv
package asram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WSETUP  = 3'd1,
    ST_WSTROBE = 3'd2,
    ST_WHOLD   = 3'd3,
    ST_RACCESS = 3'd4
  } asram_state_e;
endpackage

// File: rtl/asram_win_timer.sv
module asram_win_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // a loaded window counts down by exactly one each cycle
  p_count_down_r3: assert property (@(posedge clk) disable iff (rst)
    (!load && !expired) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 16,
  parameter int SETUP_CYC  = 1,
  parameter int PULSE_CYC  = 1,
  parameter int HOLD_CYC   = 1,
  parameter int ACCESS_CYC = 2,
  parameter int CW         = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              tmr_expired,
  output logic              tmr_load,
  output logic [CW-1:0]     tmr_val,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam logic [CW-1:0] SETUP_LD  = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] PULSE_LD  = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] HOLD_LD   = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] ACCESS_LD = CW'(ACCESS_CYC - 1);

  asram_state_e state, nxt;
  logic         rd_done;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      ST_IDLE: if (req_valid) begin
        tmr_load = 1'b1;
        if (req_write) begin nxt = ST_WSETUP;  tmr_val = SETUP_LD;  end
        else           begin nxt = ST_RACCESS; tmr_val = ACCESS_LD; end
      end
      ST_WSETUP:  if (tmr_expired) begin
        nxt = ST_WSTROBE; tmr_load = 1'b1; tmr_val = PULSE_LD;
      end
      ST_WSTROBE: if (tmr_expired) begin
        nxt = ST_WHOLD; tmr_load = 1'b1; tmr_val = HOLD_LD;
      end
      ST_WHOLD:   if (tmr_expired) nxt = ST_IDLE;
      ST_RACCESS: if (tmr_expired) nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  assign rd_done = (state == ST_RACCESS) && tmr_expired;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      req_ready   <= 1'b1;
      sram_we_n   <= 1'b1;
      sram_oe_n   <= 1'b1;
      sram_dq_oe  <= 1'b0;
      sram_addr   <= '0;
      sram_dq_out <= '0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      state      <= nxt;
      req_ready  <= (nxt == ST_IDLE);
      sram_we_n  <= (nxt != ST_WSTROBE);
      sram_oe_n  <= (nxt != ST_RACCESS);
      sram_dq_oe <= (nxt == ST_WSETUP) || (nxt == ST_WSTROBE) || (nxt == ST_WHOLD);
      rsp_valid  <= rd_done;
      if (rd_done) rsp_rdata <= sram_dq_in;
      if (state == ST_IDLE && req_valid) begin
        sram_addr   <= req_addr;
        sram_dq_out <= req_wdata;
      end
    end
  end

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(!sram_we_n && !sram_oe_n));
  p_no_contention_r7: assert property (@(posedge clk) disable iff (rst)
    !(sram_dq_oe && !sram_oe_n));
  p_we_gap_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_we_n) |-> $past(sram_oe_n));
  p_oe_gap_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_oe_n) |-> $past(sram_we_n));
  p_we_setup_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_we_n) |-> ($past(sram_dq_oe) && $stable(sram_addr) && $stable(sram_dq_out)));
  p_we_hold_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (sram_dq_oe && $stable(sram_addr) && $stable(sram_dq_out)));
  p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 16,
  parameter int SETUP_CYC  = 1,
  parameter int PULSE_CYC  = 1,
  parameter int HOLD_CYC   = 1,
  parameter int ACCESS_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int MAX_A  = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_B  = (HOLD_CYC > ACCESS_CYC) ? HOLD_CYC : ACCESS_CYC;
  localparam int MAX_WN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW     = (MAX_WN > 1) ? $clog2(MAX_WN) : 1;

  logic          tmr_expired;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;

  asram_win_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  asram_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC), .ACCESS_CYC(ACCESS_CYC), .CW(CW)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .sram_addr   (sram_addr),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe),
    .sram_dq_in  (sram_dq_in)
  );
endmodule

// File: tb/tb_asram_ctrl.sv
`timescale 1ns/1ps
module tb_asram_ctrl;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int S  = 2;
  localparam int P  = 2;
  localparam int H  = 2;
  localparam int A  = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [DW-1:0] rsp_rdata, sram_dq_out, sram_dq_in;
  logic [AW-1:0] sram_addr;

  always #2.5 clk = ~clk;

  asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(S), .PULSE_CYC(P),
               .HOLD_CYC(H), .ACCESS_CYC(A)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in));

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // external RAM model: junk until the output strobe has been low for A cycles
  logic [DW-1:0] sram [0:255];
  logic [DW-1:0] ref_mem [0:255];
  int oe_low = 0;
  initial for (int i = 0; i < 256; i++) begin
    sram[i]    = DW'(i * 37 + 11);
    ref_mem[i] = DW'(i * 37 + 11);
  end
  always @(posedge clk) begin
    if (!sram_we_n && sram_dq_oe) sram[sram_addr] <= sram_dq_out;
    oe_low <= sram_oe_n ? 0 : oe_low + 1;
  end
  assign sram_dq_in = (!sram_oe_n && oe_low >= A - 1) ? sram[sram_addr]
                                                      : (sram[sram_addr] ^ 16'hA5C3);

  // reference model, advanced on each clock
  bit            seen_edge = 1'b0;
  bit            m_busy = 1'b0, m_wr = 1'b0, m_valid = 1'b0;
  int            m_n = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wdata = '0, m_rdata = '0;

  always @(posedge clk) begin
    seen_edge = 1'b1;
    if (rst) begin
      m_busy = 1'b0; m_valid = 1'b0; m_n = 0;
    end else begin
      m_valid = 1'b0;
      if (m_busy) begin
        m_n++;
        if (m_wr && m_n == S + P + H) m_busy = 1'b0;
        else if (!m_wr && m_n == A) begin
          m_busy = 1'b0; m_valid = 1'b1; m_rdata = ref_mem[m_addr];
        end
      end else if (req_valid) begin
        m_busy = 1'b1; m_n = 0; m_wr = req_write;
        m_addr = req_addr; m_wdata = req_wdata;
        if (req_write) ref_mem[req_addr] = req_wdata;
      end
    end
  end

  always @(negedge clk) if (seen_edge) begin
    bit e_we_n;
    e_we_n = !(m_busy && m_wr && m_n >= S && m_n < S + P);
    chk(req_ready == !m_busy, rst ? "R1 ready" : "R2/R9 ready", 32'(req_ready), 32'(!m_busy));
    chk(sram_we_n == e_we_n, rst ? "R1 we_n" : "R3 we_n", 32'(sram_we_n), 32'(e_we_n));
    chk(sram_oe_n == !(m_busy && !m_wr), rst ? "R1 oe_n" : "R5 oe_n", 32'(sram_oe_n), 32'(!(m_busy && !m_wr)));
    chk(sram_dq_oe == (m_busy && m_wr), rst ? "R1 dq_oe" : "R4 dq_oe", 32'(sram_dq_oe), 32'(m_busy && m_wr));
    chk(!(!sram_we_n && !sram_oe_n), "R7 strobes", 32'({sram_we_n, sram_oe_n}), 32'h3);
    chk(rsp_valid == m_valid, rst ? "R1 rsp_valid" : "R6 rsp_valid", 32'(rsp_valid), 32'(m_valid));
    if (m_busy) chk(sram_addr == m_addr, "R2 addr", 32'(sram_addr), 32'(m_addr));
    if (m_busy && m_wr) chk(sram_dq_out == m_wdata, "R4 wdata", 32'(sram_dq_out), 32'(m_wdata));
    if (m_valid) chk(rsp_rdata == m_rdata, "R6 rdata", 32'(rsp_rdata), 32'(m_rdata));
  end

  task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // request presented while busy: R2 says it must be ignored
  task automatic poke_busy(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    issue(1'b1, 8'h00, 16'h1234);            // R3 R4 write at lowest address
    issue(1'b1, 8'hFF, 16'hFFFF);            // R3 write all ones at top address
    issue(1'b1, 8'h40, 16'h0000);            // R3 write zero
    issue(1'b0, 8'h00, 16'h0);               // R5 R6 read back
    issue(1'b0, 8'hFF, 16'h0);
    issue(1'b0, 8'h40, 16'h0);
    issue(1'b0, 8'h17, 16'h0);               // R6 untouched location
    issue(1'b1, 8'h17, 16'hBEEF);            // R8 read then write turnaround
    issue(1'b0, 8'h17, 16'h0);               // R8 write then read turnaround
    issue(1'b1, 8'h21, 16'hCAFE);
    poke_busy(1'b1, 8'h21, 16'hDEAD);        // R2 ignored while writing
    issue(1'b0, 8'h21, 16'h0);
    poke_busy(1'b1, 8'h21, 16'h5555);        // R2 ignored while reading
    issue(1'b0, 8'h21, 16'h0);               // R2 location still holds CAFE
    // R9 request held continuously: accepted at each idle cycle
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h40;
    repeat (12) @(negedge clk);
    req_valid = 1'b0;
    drain();
    // R1 reset in the middle of a read
    issue(1'b0, 8'h33, 16'h0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    issue(1'b1, 8'h33, 16'h7E81);
    issue(1'b0, 8'h33, 16'h0);
    drain();
    finish_run();
  end

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule